// File: doc/BRIEF.md
# Trap Cause and Delegation Router

This block decides, for every cycle of a small privileged core, whether a trap is taken, which cause it reports and which privilege level handles it. It looks at the synchronous exception requests, the environment-call request, the pending and enabled interrupt lines, both delegation masks, the current privilege and the current status word. From these it produces the cause value and target level, a select between the machine and supervisor trap vector and epc, the address to write into the selected epc, and the next privilege and status word for trap entry or for a return.

All results are registered: the inputs presented in one cycle show up on the outputs after the next rising clock edge. The status word and privilege are held in a register file outside the block. `priv_o` and `stat_o` always carry the next values for them, which are the inputs passed through unchanged when no event occurs. The cause, target, vector select and epc outputs keep their last trap values until the next trap.

Top module: `trap_router`

## Requirements
- R1: After reset, `trap_o` and `ret_o` are 0, `priv_o` is M (2'b11), `tgt_priv_o` is M, `vec_sel_o` is 0, and `stat_o`, `cause_o` and `epc_o` are 0.
- R2: Only `exc_i` bits 2, 3, 4, 6, 12, 13 and 15 are synchronous causes. Any other bit set in `exc_i` is ignored. When several causes are present, the lowest code wins. `cause_o[31]` is 0 for an exception and `cause_o[3:0]` holds the code.
- R3: `ecall_i` is a synchronous cause with code 8 from U (2'b00), 9 from S (2'b01) and 11 from M (2'b11). It ranks among the other exceptions by its code.
- R4: Interrupt line i carries cause i. Among eligible interrupts, the order is 11, 9, 8, 2, 1, 0, 7, 5, 4, which means external before software before timer, and within each kind machine before supervisor before user. An interrupt trap sets `cause_o[31]` to 1.
- R5: An interrupt is eligible only when its pending bit and its enable bit are both set. In addition, its global gate must be open. For an M-level target the gate is open when the privilege is below M, or when MIE (status bit 3) is 1. For an S-level target the gate is open in U, or in S when SIE (status bit 1) is 1.
- R6: A trap raised in S or U goes to S when its code bit is set in the matching delegation mask (`edeleg_i` or `ideleg_i`). It then reports `tgt_priv_o` = S and `vec_sel_o` = 1. Otherwise the trap goes to M with `vec_sel_o` = 0.
- R7: A trap raised in M is handled in M whatever the delegation masks hold.
- R8: When an exception and an eligible interrupt occur in the same cycle, the exception is taken.
- R9: On trap entry, `priv_o` becomes the target level and `epc_o` takes `pc_i`. For an M target: MPIE (bit 7) takes MIE, MIE clears, and MPP (bits 12:11) takes the old privilege. For an S target: SPIE (bit 5) takes SIE, SIE clears, and SPP (bit 8) takes bit 0 of the old privilege. All other status bits pass through.
- R10: On `mret_i`, `ret_o` pulses and `priv_o` becomes MPP. MIE takes MPIE, MPIE is set and MPP becomes U.
- R11: On `sret_i` without `mret_i`, `ret_o` pulses and `priv_o` becomes S if SPP is 1, else U. SIE takes SPIE, SPIE is set and SPP clears.
- R12: A trap in the same cycle as a return wins. The return request has no effect on that cycle's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| stat_i | input | XLEN | Current status word |
| exc_i | input | EXC_W | Synchronous exception requests, one bit per cause code |
| ecall_i | input | 1 | Environment call request |
| pc_i | input | XLEN | Address of the current instruction |
| irq_pend_i | input | IRQ_W | Pending interrupt lines |
| irq_en_i | input | IRQ_W | Interrupt enable mask |
| edeleg_i | input | EXC_W | Exception delegation mask |
| ideleg_i | input | IRQ_W | Interrupt delegation mask |
| mret_i | input | 1 | Machine return request |
| sret_i | input | 1 | Supervisor return request |
| trap_o | output | 1 | Trap-taken strobe |
| ret_o | output | 1 | Return-executed strobe |
| cause_o | output | XLEN | Cause value: interrupt flag in the top bit, code in the low bits |
| tgt_priv_o | output | 2 | Privilege that handles the last trap |
| vec_sel_o | output | 1 | 1 selects the supervisor vector and epc, 0 the machine ones |
| epc_o | output | XLEN | Value for the selected epc |
| priv_o | output | 2 | Next privilege |
| stat_o | output | XLEN | Next status word |

## Verification
Two kinds of events can fall in the same cycle. A trap (exception or interrupt) and a return (mret or sret) may both be requested. An exception and an eligible interrupt may also arrive together. The bench provokes both directly: it raises a breakpoint together with `mret_i`, and a misaligned store together with a pending machine external interrupt. The random phase also mixes return requests into cycles with traps. Each such cycle is judged by checking that only the trap side is visible: `ret_o` stays 0, the status fields follow the entry rule rather than the return rule, and the cause carries the exception code with the interrupt flag clear.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    // status word field positions
    localparam int ST_SIE  = 1;
    localparam int ST_MIE  = 3;
    localparam int ST_SPIE = 5;
    localparam int ST_MPIE = 7;
    localparam int ST_SPP  = 8;
    localparam int ST_MPP  = 11;

    // codes that a synchronous request line may raise
    localparam logic [15:0] EXC_LEGAL = 16'hB05C;

    localparam int IRQ_RANKS = 9;

    // interrupt code at a given priority rank (rank 0 is the highest)
    function automatic int irq_rank_code(input int rank);
        case (rank)
            0: return 11;
            1: return 9;
            2: return 8;
            3: return 2;
            4: return 1;
            5: return 0;
            6: return 7;
            7: return 5;
            default: return 4;
        endcase
    endfunction

    function automatic int ecall_code(input logic [1:0] priv);
        if (priv == PRIV_M) return 11;
        if (priv == PRIV_S) return 9;
        return 8;
    endfunction

endpackage

// File: rtl/trap_exc_pick.sv
module trap_exc_pick
    import trap_pkg::*;
#(
    parameter int EXC_W = 16,
    parameter int CW    = 4
) (
    input  logic [EXC_W-1:0] exc_i,
    input  logic             ecall_i,
    input  logic [1:0]       priv_i,
    output logic             hit_o,
    output logic [CW-1:0]    code_o
);
    localparam logic [EXC_W-1:0] LEGAL = EXC_W'(EXC_LEGAL);

    logic [EXC_W-1:0] req;

    always_comb begin
        req = exc_i & LEGAL;
        if (ecall_i) req[ecall_code(priv_i)] = 1'b1;
        hit_o  = |req;
        code_o = '0;
        // scan downward so the lowest code is the last one kept
        for (int i = EXC_W - 1; i >= 0; i--) begin
            if (req[i]) code_o = CW'(i);
        end
    end

endmodule

// File: rtl/trap_irq_pick.sv
module trap_irq_pick
    import trap_pkg::*;
#(
    parameter int IRQ_W = 12,
    parameter int CW    = 4
) (
    input  logic [IRQ_W-1:0] pend_i,
    input  logic [IRQ_W-1:0] en_i,
    input  logic [IRQ_W-1:0] deleg_i,
    input  logic [1:0]       priv_i,
    input  logic             mie_i,
    input  logic             sie_i,
    output logic             hit_o,
    output logic [CW-1:0]    code_o
);
    always_comb begin
        hit_o  = 1'b0;
        code_o = '0;
        // scan from the lowest rank up so rank 0 is the last one kept
        for (int r = IRQ_RANKS - 1; r >= 0; r--) begin
            int  c;
            logic to_s;
            logic gate;
            c    = irq_rank_code(r);
            to_s = (priv_i != PRIV_M) && deleg_i[c];
            gate = to_s ? ((priv_i == PRIV_U) || sie_i)
                        : ((priv_i != PRIV_M) || mie_i);
            if (pend_i[c] && en_i[c] && gate) begin
                hit_o  = 1'b1;
                code_o = CW'(c);
            end
        end
    end

endmodule

// File: rtl/trap_router.sv
module trap_router
    import trap_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int EXC_W = 16,
    parameter int IRQ_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       priv_i,
    input  logic [XLEN-1:0]  stat_i,
    input  logic [EXC_W-1:0] exc_i,
    input  logic             ecall_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [IRQ_W-1:0] irq_pend_i,
    input  logic [IRQ_W-1:0] irq_en_i,
    input  logic [EXC_W-1:0] edeleg_i,
    input  logic [IRQ_W-1:0] ideleg_i,
    input  logic             mret_i,
    input  logic             sret_i,
    output logic             trap_o,
    output logic             ret_o,
    output logic [XLEN-1:0]  cause_o,
    output logic [1:0]       tgt_priv_o,
    output logic             vec_sel_o,
    output logic [XLEN-1:0]  epc_o,
    output logic [1:0]       priv_o,
    output logic [XLEN-1:0]  stat_o
);
    localparam int CW = $clog2(EXC_W);

    typedef struct packed {
        logic            trap;
        logic            ret;
        logic [XLEN-1:0] cause;
        logic [1:0]      tgt;
        logic            vsel;
        logic [XLEN-1:0] epc;
        logic [1:0]      priv;
        logic [XLEN-1:0] stat;
    } state_t;

    state_t s_d, s_q;

    logic          exc_hit, irq_hit;
    logic [CW-1:0] exc_code, irq_code;

    trap_exc_pick #(.EXC_W(EXC_W), .CW(CW)) u_exc (
        .exc_i   (exc_i),
        .ecall_i (ecall_i),
        .priv_i  (priv_i),
        .hit_o   (exc_hit),
        .code_o  (exc_code)
    );

    trap_irq_pick #(.IRQ_W(IRQ_W), .CW(CW)) u_irq (
        .pend_i  (irq_pend_i),
        .en_i    (irq_en_i),
        .deleg_i (ideleg_i),
        .priv_i  (priv_i),
        .mie_i   (stat_i[ST_MIE]),
        .sie_i   (stat_i[ST_SIE]),
        .hit_o   (irq_hit),
        .code_o  (irq_code)
    );

    always_comb begin
        logic          is_irq;
        logic [CW-1:0] code;
        logic          dlg;
        logic          to_s;

        is_irq = !exc_hit;
        code   = exc_hit ? exc_code : irq_code;
        dlg    = exc_hit ? edeleg_i[exc_code] : ideleg_i[irq_code];
        to_s   = (priv_i != PRIV_M) && dlg;

        s_d      = s_q;
        s_d.trap = 1'b0;
        s_d.ret  = 1'b0;
        s_d.priv = priv_i;
        s_d.stat = stat_i;

        if (exc_hit || irq_hit) begin
            s_d.trap             = 1'b1;
            s_d.cause            = '0;
            s_d.cause[XLEN-1]    = is_irq;
            s_d.cause[CW-1:0]    = code;
            s_d.tgt              = to_s ? PRIV_S : PRIV_M;
            s_d.vsel             = to_s;
            s_d.epc              = pc_i;
            if (to_s) begin
                s_d.stat[ST_SPIE] = stat_i[ST_SIE];
                s_d.stat[ST_SIE]  = 1'b0;
                s_d.stat[ST_SPP]  = priv_i[0];
                s_d.priv          = PRIV_S;
            end else begin
                s_d.stat[ST_MPIE]     = stat_i[ST_MIE];
                s_d.stat[ST_MIE]      = 1'b0;
                s_d.stat[ST_MPP +: 2] = priv_i;
                s_d.priv              = PRIV_M;
            end
        end else if (mret_i) begin
            s_d.ret               = 1'b1;
            s_d.priv              = stat_i[ST_MPP +: 2];
            s_d.stat[ST_MIE]      = stat_i[ST_MPIE];
            s_d.stat[ST_MPIE]     = 1'b1;
            s_d.stat[ST_MPP +: 2] = PRIV_U;
        end else if (sret_i) begin
            s_d.ret           = 1'b1;
            s_d.priv          = {1'b0, stat_i[ST_SPP]};
            s_d.stat[ST_SIE]  = stat_i[ST_SPIE];
            s_d.stat[ST_SPIE] = 1'b1;
            s_d.stat[ST_SPP]  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.priv <= PRIV_M;
            s_q.tgt  <= PRIV_M;
        end else begin
            s_q <= s_d;
        end
    end

    assign trap_o     = s_q.trap;
    assign ret_o      = s_q.ret;
    assign cause_o    = s_q.cause;
    assign tgt_priv_o = s_q.tgt;
    assign vec_sel_o  = s_q.vsel;
    assign epc_o      = s_q.epc;
    assign priv_o     = s_q.priv;
    assign stat_o     = s_q.stat;

endmodule

// File: rtl/trap_router_chk.sv
module trap_router_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      priv_i,
    input logic [XLEN-1:0] stat_i,
    input logic [XLEN-1:0] pc_i,
    input logic            mret_i,
    input logic            sret_i,
    input logic            trap_o,
    input logic            ret_o,
    input logic [1:0]      tgt_priv_o,
    input logic            vec_sel_o,
    input logic [XLEN-1:0] epc_o,
    input logic [1:0]      priv_o,
    input logic [XLEN-1:0] stat_o
);
    a_r9_priv_follows_target: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> priv_o == tgt_priv_o);

    a_r7_machine_not_delegated: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && $past(priv_i) == 2'b11) |-> (tgt_priv_o == 2'b11 && !vec_sel_o));

    a_r9_machine_entry_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && !vec_sel_o) |->
            (!stat_o[3] && stat_o[7] == $past(stat_i[3]) && stat_o[12:11] == $past(priv_i)));

    a_r9_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> epc_o == $past(pc_i));

    a_r10_mret_fields: assert property (@(posedge clk) disable iff (!rst_n)
        mret_i |=> (trap_o || (ret_o && stat_o[7] && stat_o[12:11] == 2'b00)));

    a_r11_sret_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (sret_i && !mret_i) |=> (trap_o || (ret_o && stat_o[5] && !stat_o[8])));

    a_r12_no_double_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_o && ret_o));

endmodule

bind trap_router trap_router_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .priv_i     (priv_i),
    .stat_i     (stat_i),
    .pc_i       (pc_i),
    .mret_i     (mret_i),
    .sret_i     (sret_i),
    .trap_o     (trap_o),
    .ret_o      (ret_o),
    .tgt_priv_o (tgt_priv_o),
    .vec_sel_o  (vec_sel_o),
    .epc_o      (epc_o),
    .priv_o     (priv_o),
    .stat_o     (stat_o)
);

// File: tb/sim_trap_router.sv
module sim_trap_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv_i;
    logic [31:0] stat_i;
    logic [15:0] exc_i;
    logic        ecall_i;
    logic [31:0] pc_i;
    logic [11:0] irq_pend_i, irq_en_i, ideleg_i;
    logic [15:0] edeleg_i;
    logic        mret_i, sret_i;
    logic        trap_o, ret_o, vec_sel_o;
    logic [31:0] cause_o, epc_o, stat_o;
    logic [1:0]  tgt_priv_o, priv_o;

    int tests = 0;
    int fails = 0;

    // expected values; cause/tgt/vsel/epc persist between traps
    logic        e_trap, e_ret, e_vsel;
    logic [31:0] e_cause, e_epc, e_stat;
    logic [1:0]  e_tgt, e_priv;

    always #5 clk = ~clk;

    trap_router u0 (
        .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .stat_i(stat_i),
        .exc_i(exc_i), .ecall_i(ecall_i), .pc_i(pc_i),
        .irq_pend_i(irq_pend_i), .irq_en_i(irq_en_i),
        .edeleg_i(edeleg_i), .ideleg_i(ideleg_i),
        .mret_i(mret_i), .sret_i(sret_i),
        .trap_o(trap_o), .ret_o(ret_o), .cause_o(cause_o),
        .tgt_priv_o(tgt_priv_o), .vec_sel_o(vec_sel_o), .epc_o(epc_o),
        .priv_o(priv_o), .stat_o(stat_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int bench_ecall(input logic [1:0] p);
        return (p == 2'b11) ? 11 : (p == 2'b01) ? 9 : 8;
    endfunction

    // expected outcome from the requirements for the current inputs
    function automatic void predict();
        int exl[10] = '{2, 3, 4, 6, 8, 9, 11, 12, 13, 15};
        int ord[9]  = '{11, 9, 8, 2, 1, 0, 7, 5, 4};
        int ec = -1;
        int ic = -1;
        int code;
        logic isirq, dl, tos, ok;
        for (int k = 0; k < 10; k++) begin
            int c = exl[k];
            logic h;
            if (c == 8 || c == 9 || c == 11) h = ecall_i && (c == bench_ecall(priv_i));
            else h = exc_i[c];
            if (ec < 0 && h) ec = c;
        end
        for (int k = 0; k < 9; k++) begin
            int c = ord[k];
            dl = (priv_i != 2'b11) && ideleg_i[c];
            ok = dl ? (priv_i == 2'b00 || stat_i[1]) : (priv_i != 2'b11 || stat_i[3]);
            if (ic < 0 && irq_pend_i[c] && irq_en_i[c] && ok) ic = c;
        end
        e_trap = 1'b0; e_ret = 1'b0; e_priv = priv_i; e_stat = stat_i;
        if (ec >= 0 || ic >= 0) begin
            isirq = (ec < 0);
            code = isirq ? ic : ec;
            dl = isirq ? ideleg_i[code] : edeleg_i[code];
            tos = (priv_i != 2'b11) && dl;
            e_trap = 1'b1;
            e_cause = {isirq, 27'd0, 4'(code)};
            e_tgt = tos ? 2'b01 : 2'b11;
            e_vsel = tos;
            e_epc = pc_i;
            if (tos) begin
                e_stat[5] = stat_i[1]; e_stat[1] = 1'b0; e_stat[8] = priv_i[0]; e_priv = 2'b01;
            end else begin
                e_stat[7] = stat_i[3]; e_stat[3] = 1'b0; e_stat[12:11] = priv_i; e_priv = 2'b11;
            end
        end else if (mret_i) begin
            e_ret = 1'b1; e_priv = stat_i[12:11];
            e_stat[3] = stat_i[7]; e_stat[7] = 1'b1; e_stat[12:11] = 2'b00;
        end else if (sret_i) begin
            e_ret = 1'b1; e_priv = {1'b0, stat_i[8]};
            e_stat[1] = stat_i[5]; e_stat[5] = 1'b1; e_stat[8] = 1'b0;
        end
    endfunction

    task automatic idle();
        priv_i = 2'b11; stat_i = '0; exc_i = '0; ecall_i = 1'b0; pc_i = 32'h1000;
        irq_pend_i = '0; irq_en_i = '0; edeleg_i = '0; ideleg_i = '0;
        mret_i = 1'b0; sret_i = 1'b0;
    endtask

    // inputs are stable at a falling edge; predict, cross one rising edge, compare
    task automatic step(input string tag);
        predict();
        @(negedge clk);
        chk(tag, "trap", 32'(trap_o), 32'(e_trap));
        chk(tag, "ret", 32'(ret_o), 32'(e_ret));
        chk(tag, "cause", cause_o, e_cause);
        chk(tag, "tgt", 32'(tgt_priv_o), 32'(e_tgt));
        chk(tag, "vsel", 32'(vec_sel_o), 32'(e_vsel));
        chk(tag, "epc", epc_o, e_epc);
        chk(tag, "priv", 32'(priv_o), 32'(e_priv));
        chk(tag, "stat", stat_o, e_stat);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "trap", 32'(trap_o), 0);
        chk("R1", "ret", 32'(ret_o), 0);
        chk("R1", "priv", 32'(priv_o), 3);
        chk("R1", "tgt", 32'(tgt_priv_o), 3);
        chk("R1", "stat", stat_o, 0);
        chk("R1", "cause", cause_o, 0);
        e_cause = '0; e_tgt = 2'b11; e_vsel = 1'b0; e_epc = '0;
        rst_n = 1'b1;

        // R2: lowest legal code wins; illegal bits ignored
        idle(); exc_i = 16'h2010; pc_i = 32'h40; step("R2");
        chk("R2", "code", cause_o, 32'd4);
        idle(); exc_i = 16'h0EA3; stat_i = 32'h88; step("R2");
        chk("R2", "ignored", 32'(trap_o), 0);
        chk("R2", "stat untouched", stat_o, 32'h88);
        // R3: environment call codes
        idle(); priv_i = 2'b00; ecall_i = 1'b1; step("R3");
        chk("R3", "U code", cause_o, 32'd8);
        idle(); priv_i = 2'b01; ecall_i = 1'b1; step("R3");
        chk("R3", "S code", cause_o, 32'd9);
        idle(); ecall_i = 1'b1; exc_i = 16'h1000; step("R3");
        chk("R3", "M code", cause_o, 32'd11);
        // R4: interrupt ordering
        idle(); priv_i = 2'b00; irq_pend_i = 12'hFFF; irq_en_i = 12'hFFF; step("R4");
        chk("R4", "ext first", cause_o, 32'h8000000B);
        idle(); priv_i = 2'b00; irq_pend_i = 12'h0B0; irq_en_i = 12'hFFF; step("R4");
        chk("R4", "timer M", cause_o, 32'h80000007);
        idle(); priv_i = 2'b00; irq_pend_i = 12'h0B3; irq_en_i = 12'hFFF; step("R4");
        chk("R4", "sw before timer", cause_o, 32'h80000001);
        // R5: gating
        idle(); irq_pend_i = 12'h080; irq_en_i = 12'h080; step("R5");
        chk("R5", "MIE clear masks", 32'(trap_o), 0);
        idle(); stat_i = 32'h8; irq_pend_i = 12'h080; irq_en_i = 12'h000; step("R5");
        chk("R5", "enable clear masks", 32'(trap_o), 0);
        idle(); stat_i = 32'h8; irq_pend_i = 12'h080; irq_en_i = 12'h080; step("R5");
        chk("R5", "taken", 32'(trap_o), 1);
        // R6: delegation to S
        idle(); priv_i = 2'b00; exc_i = 16'h0004; edeleg_i = 16'h0004; stat_i = 32'h2; step("R6");
        chk("R6", "vsel", 32'(vec_sel_o), 1);
        chk("R9", "S entry stat", stat_o, 32'h20);
        idle(); priv_i = 2'b01; irq_pend_i = 12'h020; irq_en_i = 12'h020; ideleg_i = 12'h020; step("R6");
        chk("R6", "SIE clear masks", 32'(trap_o), 0);
        idle(); priv_i = 2'b01; stat_i = 32'h2; irq_pend_i = 12'h020; irq_en_i = 12'h020;
        ideleg_i = 12'h020; step("R6");
        chk("R6", "tgt S", 32'(tgt_priv_o), 1);
        // R7: M never delegates
        idle(); exc_i = 16'h0008; edeleg_i = 16'hFFFF; step("R7");
        chk("R7", "tgt M", 32'(tgt_priv_o), 3);
        // R8: exception beats interrupt
        idle(); priv_i = 2'b00; exc_i = 16'h0040; irq_pend_i = 12'h800; irq_en_i = 12'h800; step("R8");
        chk("R8", "cause", cause_o, 32'd6);
        // R9: M entry from S
        idle(); priv_i = 2'b01; stat_i = 32'h8; exc_i = 16'h2000; pc_i = 32'hABC0; step("R9");
        chk("R9", "M entry stat", stat_o, 32'h880);
        chk("R9", "epc", epc_o, 32'hABC0);
        // R10 / R11 returns
        idle(); mret_i = 1'b1; stat_i = 32'h880; step("R10");
        chk("R10", "priv", 32'(priv_o), 1);
        chk("R10", "stat", stat_o, 32'h88);
        idle(); priv_i = 2'b01; sret_i = 1'b1; stat_i = 32'h120; step("R11");
        chk("R11", "priv", 32'(priv_o), 1);
        chk("R11", "stat", stat_o, 32'h22);
        // R12: trap wins over return
        idle(); mret_i = 1'b1; sret_i = 1'b1; exc_i = 16'h0008; stat_i = 32'h1888; step("R12");
        chk("R12", "no ret", 32'(ret_o), 0);
        chk("R12", "priv", 32'(priv_o), 3);

        // constrained random phase
        void'($urandom(32'h1A2B3C4D));
        for (int n = 0; n < 3000; n++) begin
            int pr = $urandom_range(0, 2);
            string tag;
            priv_i = (pr == 2) ? 2'b11 : 2'(pr);
            stat_i = $urandom;
            exc_i = 16'($urandom & $urandom & $urandom);
            ecall_i = ($urandom_range(0, 7) == 0);
            pc_i = $urandom;
            irq_pend_i = 12'($urandom);
            irq_en_i = 12'($urandom);
            edeleg_i = 16'($urandom);
            ideleg_i = 12'($urandom);
            mret_i = ($urandom_range(0, 5) == 0);
            sret_i = ($urandom_range(0, 5) == 0);
            predict();
            tag = e_trap ? (e_cause[31] ? "R4" : "R2") : (e_ret ? (mret_i ? "R10" : "R11") : "R5");
            step(tag);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule